// File: doc/BRIEF.md
# Vector Floating-Point Compare-to-Mask Unit

This unit executes vector floating-point comparisons whose result is a packed mask holding one bit per element. It takes a 32-bit instruction word on a start pulse and decodes it. It then walks the elements one per clock. For each active element it compares a lane of `vec_a` with either the matching lane of `vec_b` or a single scalar shared by every lane. The outcome is written into bit *i* of the destination mask.

The prior destination mask comes in on `dest_in`. Bits the instruction does not touch keep their prior value. A one-cycle `done` pulse ends each instruction. `illegal` reports an instruction that must not execute, and `invalid` reports an IEEE invalid-operation exception. The caller supplies the operand buses and the source mask. The caller must hold them, and the instruction word, stable until `done`.

Top module: `vfcmp_mask_unit`

## Requirements
- R1: The instruction is legal only when bits [6:0] equal 1010111 and bits [14:12] equal 001 (vector-vector form) or 101 (vector-scalar form). Bits [31:26] select the comparison, and bit 25 is the mask-enable bit. Any other major opcode or form code raises `illegal`.
- R2: The function codes are eq=011000, le=011001, lt=011011, ne=011100, gt=011101 and ge=011111. gt and ge are legal only in the vector-scalar form. Any other code, or gt/ge in the vector-vector form, raises `illegal`.
- R3: The left operand is lane i of `vec_a`. The right operand is lane i of `vec_b` in the vector-vector form, and `scalar_op` for every lane in the vector-scalar form.
- R4: `ew_sel` 01 selects 16-bit elements, held in the low half of each 32-bit lane and of `scalar_op`. `ew_sel` 10 selects 32-bit elements. Code 00 (8-bit) and code 11 are illegal. An illegal instruction raises `illegal` with `done`, leaves `invalid` at 0, and returns `dest_out` equal to `dest_in`.
- R5: With bit 25 = 1 every lane below the count is active. With bit 25 = 0, lane i is active only when `src_mask[i]` is 1. An inactive lane produces no result bit and no exception.
- R6: At start, `dest_out` takes `dest_in`. Bits of inactive lanes and of lanes at or above `elem_cnt` keep that value. A count above MAX_ELEM acts as MAX_ELEM.
- R7: ne is the inverse of eq. If either operand is NaN, eq gives 0, ne gives 1, and lt, le, gt and ge give 0.
- R8: `invalid` is cleared at start and accumulates over active lanes. eq and ne set it only for a signaling NaN operand. lt, le, gt and ge set it for any NaN operand.
- R9: Ordering follows signed IEEE values, infinities included, and +0 equals -0.
- R10: Suppose start is taken at clock edge E0 and the instruction is legal with N ≥ 1 active-count lanes. Then `busy` is high until the edge that handles the last lane, and `done` is high for exactly one cycle after edge E(N). For an illegal instruction, or for N = 0, `done` follows E0 directly.
- R11: `elem_idx` gives the lane being handled while busy. It reads 0 whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (ignored while busy) |
| instr | input | 32 | Instruction word |
| elem_cnt | input | CNT_W | Number of elements |
| ew_sel | input | 2 | Element width code |
| src_mask | input | MAX_ELEM | Source enable mask |
| scalar_op | input | 32 | Scalar right operand |
| vec_a | input | MAX_ELEM*32 | Left operand lanes |
| vec_b | input | MAX_ELEM*32 | Right operand lanes |
| dest_in | input | MAX_ELEM | Prior destination mask |
| busy | output | 1 | Elements in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Instruction rejected |
| invalid | output | 1 | Invalid-operation exception |
| dest_out | output | MAX_ELEM | Destination mask |
| elem_idx | output | IDX_W | Current lane / start index |

## Verification
The bound checker watches several properties on every cycle. It confirms that each step changes at most the bit of the current lane, and that an inactive lane leaves the mask untouched. It also confirms that the mask is loaded from `dest_in` at start and stays frozen while idle, that an illegal report comes with `done`, and that `done` is a single pulse with the index back at zero. The IEEE comparison results themselves are shown only by the bench's scenarios. These cover NaN handling and exception flags, signed zeros, the choice of scalar over lane, 16-bit lane extraction, decode rejections and latency.

// File: rtl/vfcmp_pkg.sv
package vfcmp_pkg;

    localparam logic [6:0] VEC_MAJOR = 7'b1010111;
    localparam logic [2:0] F3_VV     = 3'b001;
    localparam logic [2:0] F3_VF     = 3'b101;

    localparam logic [5:0] F6_EQ = 6'b011000;
    localparam logic [5:0] F6_LE = 6'b011001;
    localparam logic [5:0] F6_LT = 6'b011011;
    localparam logic [5:0] F6_NE = 6'b011100;
    localparam logic [5:0] F6_GT = 6'b011101;
    localparam logic [5:0] F6_GE = 6'b011111;

    localparam logic [1:0] EW_16 = 2'b01;
    localparam logic [1:0] EW_32 = 2'b10;

    typedef enum logic [2:0] {
        OP_EQ = 3'd0,
        OP_LE = 3'd1,
        OP_LT = 3'd2,
        OP_NE = 3'd3,
        OP_GT = 3'd4,
        OP_GE = 3'd5
    } cmp_op_e;

    typedef struct packed {
        logic    legal;
        cmp_op_e op;
        logic    scalar;
        logic    unmasked;
        logic    half;
    } dec_t;

endpackage

// File: rtl/vfcmp_decode.sv
module vfcmp_decode
    import vfcmp_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [1:0]  ew_sel,
    output dec_t        dec
);
    logic [5:0] f6;
    logic [2:0] f3;
    logic       form_vv;
    logic       form_vf;
    logic       func_ok;
    logic       width_ok;
    cmp_op_e    op_sel;

    always_comb begin
        f6       = instr[31:26];
        f3       = instr[14:12];
        form_vv  = (f3 == F3_VV);
        form_vf  = (f3 == F3_VF);
        width_ok = (ew_sel == EW_16) || (ew_sel == EW_32);
        func_ok  = 1'b1;
        op_sel   = OP_EQ;
        case (f6)
            F6_EQ:   op_sel = OP_EQ;
            F6_LE:   op_sel = OP_LE;
            F6_LT:   op_sel = OP_LT;
            F6_NE:   op_sel = OP_NE;
            F6_GT: begin
                op_sel  = OP_GT;
                func_ok = form_vf;
            end
            F6_GE: begin
                op_sel  = OP_GE;
                func_ok = form_vf;
            end
            default: func_ok = 1'b0;
        endcase
        dec.legal    = (instr[6:0] == VEC_MAJOR) && (form_vv || form_vf) && func_ok && width_ok;
        dec.op       = op_sel;
        dec.scalar   = form_vf;
        dec.unmasked = instr[25];
        dec.half     = (ew_sel == EW_16);
    end
endmodule

// File: rtl/vfcmp_class.sv
module vfcmp_class (
    input  logic [31:0] val,
    input  logic        half,
    output logic        is_nan,
    output logic        is_snan,
    output logic        is_zero,
    output logic        sign,
    output logic [30:0] mag
);
    logic exp_ones;
    logic mant_nz;
    logic quiet;

    always_comb begin
        if (half) begin
            exp_ones = &val[14:10];
            mant_nz  = |val[9:0];
            quiet    = val[9];
            sign     = val[15];
            mag      = {16'b0, val[14:0]};
        end else begin
            exp_ones = &val[30:23];
            mant_nz  = |val[22:0];
            quiet    = val[22];
            sign     = val[31];
            mag      = val[30:0];
        end
        is_nan  = exp_ones && mant_nz;
        is_snan = is_nan && !quiet;
        is_zero = (mag == '0);
    end
endmodule

// File: rtl/vfcmp_elem.sv
module vfcmp_elem
    import vfcmp_pkg::*;
(
    input  logic [31:0] lhs,
    input  logic [31:0] rhs,
    input  logic        half,
    input  cmp_op_e     op,
    output logic        result,
    output logic        nv
);
    logic [31:0] opnd [2];
    logic        nan  [2];
    logic        snan [2];
    logic        zero [2];
    logic        sgn  [2];
    logic [30:0] mag  [2];

    assign opnd[0] = lhs;
    assign opnd[1] = rhs;

    for (genvar k = 0; k < 2; k++) begin : g_cls
        vfcmp_class u_cls (
            .val     (opnd[k]),
            .half    (half),
            .is_nan  (nan[k]),
            .is_snan (snan[k]),
            .is_zero (zero[k]),
            .sign    (sgn[k]),
            .mag     (mag[k])
        );
    end

    logic unord;
    logic both_zero;
    logic same;
    logic less_ab;
    logic less_ba;

    always_comb begin
        unord     = nan[0] || nan[1];
        both_zero = zero[0] && zero[1];
        same      = both_zero || ((sgn[0] == sgn[1]) && (mag[0] == mag[1]));
        less_ab   = !both_zero && (( sgn[0] && !sgn[1]) ||
                                   (!sgn[0] && !sgn[1] && (mag[0] < mag[1])) ||
                                   ( sgn[0] &&  sgn[1] && (mag[0] > mag[1])));
        less_ba   = !both_zero && (( sgn[1] && !sgn[0]) ||
                                   (!sgn[1] && !sgn[0] && (mag[1] < mag[0])) ||
                                   ( sgn[1] &&  sgn[0] && (mag[1] > mag[0])));
        unique case (op)
            OP_EQ:   result = !unord && same;
            OP_NE:   result = !(!unord && same);
            OP_LT:   result = !unord && less_ab;
            OP_LE:   result = !unord && (less_ab || same);
            OP_GT:   result = !unord && less_ba;
            OP_GE:   result = !unord && (less_ba || same);
            default: result = 1'b0;
        endcase
        if (op == OP_EQ || op == OP_NE) nv = snan[0] || snan[1];
        else                            nv = unord;
    end
endmodule

// File: rtl/vfcmp_mask_unit.sv
module vfcmp_mask_unit
    import vfcmp_pkg::*;
#(
    parameter int MAX_ELEM = 8,
    localparam int LANE_W  = 32,
    localparam int CNT_W   = $clog2(MAX_ELEM + 1),
    localparam int IDX_W   = (MAX_ELEM > 1) ? $clog2(MAX_ELEM) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [31:0]                instr,
    input  logic [CNT_W-1:0]           elem_cnt,
    input  logic [1:0]                 ew_sel,
    input  logic [MAX_ELEM-1:0]        src_mask,
    input  logic [31:0]                scalar_op,
    input  logic [MAX_ELEM*LANE_W-1:0] vec_a,
    input  logic [MAX_ELEM*LANE_W-1:0] vec_b,
    input  logic [MAX_ELEM-1:0]        dest_in,
    output logic                       busy,
    output logic                       done,
    output logic                       illegal,
    output logic                       invalid,
    output logic [MAX_ELEM-1:0]        dest_out,
    output logic [IDX_W-1:0]           elem_idx
);
    typedef struct packed {
        logic                running;
        logic [IDX_W-1:0]    idx;
        logic [IDX_W-1:0]    last;
        cmp_op_e             op;
        logic                scalar;
        logic                unmasked;
        logic                half;
        logic [MAX_ELEM-1:0] dest;
        logic                done;
        logic                illegal;
        logic                invalid;
    } st_t;

    st_t st_d, st_q;

    logic [LANE_W-1:0] lane_a [MAX_ELEM];
    logic [LANE_W-1:0] lane_b [MAX_ELEM];

    for (genvar i = 0; i < MAX_ELEM; i++) begin : g_lane
        assign lane_a[i] = vec_a[i*LANE_W +: LANE_W];
        assign lane_b[i] = vec_b[i*LANE_W +: LANE_W];
    end

    dec_t dec;

    vfcmp_decode u_dec (
        .instr  (instr),
        .ew_sel (ew_sel),
        .dec    (dec)
    );

    logic [LANE_W-1:0] lhs;
    logic [LANE_W-1:0] rhs;
    logic              cmp_res;
    logic              cmp_nv;

    assign lhs = lane_a[st_q.idx];
    assign rhs = st_q.scalar ? scalar_op : lane_b[st_q.idx];

    vfcmp_elem u_elem (
        .lhs    (lhs),
        .rhs    (rhs),
        .half   (st_q.half),
        .op     (st_q.op),
        .result (cmp_res),
        .nv     (cmp_nv)
    );

    logic [CNT_W-1:0] cnt_eff;
    logic [CNT_W-1:0] cnt_m1;
    logic             lane_on;

    always_comb begin
        cnt_eff = (elem_cnt > CNT_W'(MAX_ELEM)) ? CNT_W'(MAX_ELEM) : elem_cnt;
        cnt_m1  = cnt_eff - 1'b1;
        lane_on = st_q.unmasked || src_mask[st_q.idx];
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start && !st_q.running) begin
            st_d.dest     = dest_in;
            st_d.illegal  = !dec.legal;
            st_d.invalid  = 1'b0;
            st_d.idx      = '0;
            st_d.op       = dec.op;
            st_d.scalar   = dec.scalar;
            st_d.unmasked = dec.unmasked;
            st_d.half     = dec.half;
            st_d.last     = cnt_m1[IDX_W-1:0];
            if (!dec.legal || cnt_eff == '0) begin
                st_d.done = 1'b1;
            end else begin
                st_d.running = 1'b1;
            end
        end else if (st_q.running) begin
            if (lane_on) begin
                st_d.dest[st_q.idx] = cmp_res;
                st_d.invalid        = st_q.invalid || cmp_nv;
            end
            if (st_q.idx == st_q.last) begin
                st_d.running = 1'b0;
                st_d.done    = 1'b1;
                st_d.idx     = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.running;
    assign done     = st_q.done;
    assign illegal  = st_q.illegal;
    assign invalid  = st_q.invalid;
    assign dest_out = st_q.dest;
    assign elem_idx = st_q.idx;

endmodule

// File: rtl/vfcmp_mask_unit_chk.sv
module vfcmp_mask_unit_chk #(
    parameter int MAX_ELEM = 8,
    localparam int CNT_W   = $clog2(MAX_ELEM + 1),
    localparam int IDX_W   = (MAX_ELEM > 1) ? $clog2(MAX_ELEM) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [31:0]         instr,
    input logic [MAX_ELEM-1:0] src_mask,
    input logic [MAX_ELEM-1:0] dest_in,
    input logic                busy,
    input logic                done,
    input logic                illegal,
    input logic [MAX_ELEM-1:0] dest_out,
    input logic [IDX_W-1:0]    elem_idx
);
    localparam logic [MAX_ELEM-1:0] LSB_ONE = MAX_ELEM'(1);

    AST_LOAD_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (dest_out == $past(dest_in))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !busy) |=> $stable(dest_out)); // R4

    AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (((dest_out ^ $past(dest_out)) & ~(LSB_ONE << $past(elem_idx))) == '0)); // R6

    AST_INACTIVE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !instr[25] && !src_mask[elem_idx]) |=> $stable(dest_out)); // R5

    AST_ILLEGAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal) |-> (done && !busy)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done); // R10

    AST_IDX_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (elem_idx == '0)); // R11

endmodule

bind vfcmp_mask_unit vfcmp_mask_unit_chk #(.MAX_ELEM(MAX_ELEM)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .instr    (instr),
    .src_mask (src_mask),
    .dest_in  (dest_in),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .dest_out (dest_out),
    .elem_idx (elem_idx)
);

// File: tb/vfcmp_mask_unit_bench.sv
module vfcmp_mask_unit_bench;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   instr = '0;
    logic [2:0]    elem_cnt = '0;
    logic [1:0]    ew_sel = '0;
    logic [N-1:0]  src_mask = '0;
    logic [31:0]   scalar_op = '0;
    logic [N*32-1:0] vec_a = '0;
    logic [N*32-1:0] vec_b = '0;
    logic [N-1:0]  dest_in = '0;
    logic          busy, done, illegal, invalid;
    logic [N-1:0]  dest_out;
    logic [1:0]    elem_idx;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vfcmp_mask_unit #(.MAX_ELEM(N)) u_vfcmp_mask_unit (
        .clk, .rst_n, .start, .instr, .elem_cnt, .ew_sel, .src_mask, .scalar_op,
        .vec_a, .vec_b, .dest_in, .busy, .done, .illegal, .invalid, .dest_out, .elem_idx
    );

    typedef struct packed {
        logic [5:0]   f6;
        logic [2:0]   f3;
        logic         vm;
        logic [1:0]   ew;
        logic [2:0]   cnt;
        logic [3:0]   smask;
        logic [31:0]  scal;
        logic [127:0] a;
        logic [127:0] b;
        logic [3:0]   din;
        logic [3:0]   exp;
        logic         ill;
        logic         inv;
    } row_t;

    localparam int ROWS = 17;
    localparam row_t TABLE [ROWS] = '{
        // R7 R9: eq with +0/-0 and qNaN
        '{6'b011000, 3'b001, 1'b1, 2'b10, 3'd4, 4'h0, 32'h0,
          {32'h7FC00000, 32'h00000000, 32'h40000000, 32'h3F800000},
          {32'h7FC00000, 32'h80000000, 32'h3F800000, 32'h3F800000}, 4'b1010, 4'b0101, 1'b0, 1'b0},
        // R7: ne is inverse of eq
        '{6'b011100, 3'b001, 1'b1, 2'b10, 3'd4, 4'h0, 32'h0,
          {32'h7FC00000, 32'h00000000, 32'h40000000, 32'h3F800000},
          {32'h7FC00000, 32'h80000000, 32'h3F800000, 32'h3F800000}, 4'b0000, 4'b1010, 1'b0, 1'b0},
        // R8 R3: lt, qNaN raises invalid
        '{6'b011011, 3'b001, 1'b1, 2'b10, 3'd4, 4'h0, 32'h0,
          {32'h7FC00000, 32'h3F800000, 32'h40000000, 32'hBF800000},
          {32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000}, 4'b1111, 4'b0001, 1'b0, 1'b1},
        // R9: le with negatives and infinity
        '{6'b011001, 3'b001, 1'b1, 2'b10, 3'd4, 4'h0, 32'h0,
          {32'h40000000, 32'h3F800000, 32'hBF800000, 32'hC0000000},
          {32'h7F800000, 32'hBF800000, 32'hBF800000, 32'hBF800000}, 4'b0000, 4'b1011, 1'b0, 1'b0},
        // R5 R2: masked gt with scalar
        '{6'b011101, 3'b101, 1'b0, 2'b10, 3'd4, 4'b0110, 32'h3F800000,
          {32'hBF800000, 32'h3F000000, 32'h40000000, 32'h40000000},
          128'h0, 4'b1001, 4'b1011, 1'b0, 1'b0},
        // R4 R6: 16-bit ge with scalar, tail lane kept
        '{6'b011111, 3'b101, 1'b1, 2'b01, 3'd3, 4'h0, 32'hFFFF3C00,
          {32'hFFFF0000, 32'hFFFFBC00, 32'hFFFF4000, 32'hFFFF3C00},
          128'h0, 4'b1000, 4'b1011, 1'b0, 1'b0},
        // R8 R9: 16-bit eq, sNaN raises invalid, -0 == +0
        '{6'b011000, 3'b001, 1'b1, 2'b01, 3'd4, 4'h0, 32'h0,
          {32'h00007E00, 32'h00008000, 32'h00003C00, 32'h00007C01},
          {32'h00003C00, 32'h00000000, 32'h00003C00, 32'h00003C00}, 4'b0000, 4'b0110, 1'b0, 1'b1},
        // R7 R8: 16-bit ne, qNaN gives 1 without invalid
        '{6'b011100, 3'b001, 1'b1, 2'b01, 3'd4, 4'h0, 32'h0,
          {32'h00003C00, 32'h00003C00, 32'h00004000, 32'h00007E00},
          {32'h00003C00, 32'h0000BC00, 32'h00004000, 32'h00003C00}, 4'b1111, 4'b0101, 1'b0, 1'b0},
        // R2: gt code in vector-vector form
        '{6'b011101, 3'b001, 1'b1, 2'b10, 3'd4, 4'h0, 32'h0, 128'h0, 128'h0, 4'b1100, 4'b1100, 1'b1, 1'b0},
        // R4: 8-bit width illegal
        '{6'b011000, 3'b001, 1'b1, 2'b00, 3'd4, 4'h0, 32'h0, 128'h0, 128'h0, 4'b0011, 4'b0011, 1'b1, 1'b0},
        // R1: bad form code
        '{6'b011000, 3'b011, 1'b1, 2'b10, 3'd4, 4'h0, 32'h0, 128'h0, 128'h0, 4'b0110, 4'b0110, 1'b1, 1'b0},
        // R8: signaling scalar for lt
        '{6'b011011, 3'b101, 1'b1, 2'b10, 3'd4, 4'h0, 32'h7F800001,
          {4{32'h3F800000}}, 128'h0, 4'b1111, 4'b0000, 1'b0, 1'b1},
        // R5: no active lane, NaN lanes raise nothing
        '{6'b011001, 3'b101, 1'b0, 2'b10, 3'd4, 4'b0000, 32'h3F800000,
          {4{32'h7FC00000}}, 128'h0, 4'b0101, 4'b0101, 1'b0, 1'b0},
        // R2: ge code in vector-vector form
        '{6'b011111, 3'b001, 1'b1, 2'b10, 3'd4, 4'h0, 32'h0, 128'h0, 128'h0, 4'b1001, 4'b1001, 1'b1, 1'b0},
        // R3: scalar replaces vec_b lanes
        '{6'b011000, 3'b101, 1'b1, 2'b10, 3'd4, 4'h0, 32'h40000000,
          {32'h40000000, 32'h3F800000, 32'h40000000, 32'h3F800000},
          {32'h3F800000, 32'h40000000, 32'h3F800000, 32'h40000000}, 4'b0000, 4'b1010, 1'b0, 1'b0},
        // R10 R6: zero count
        '{6'b011000, 3'b001, 1'b1, 2'b10, 3'd0, 4'h0, 32'h0, 128'h0, 128'h0, 4'b1010, 4'b1010, 1'b0, 1'b0},
        // R6 R10: count above capacity is clamped
        '{6'b011000, 3'b001, 1'b1, 2'b10, 3'd7, 4'h0, 32'h0,
          {4{32'h3F800000}}, {4{32'h3F800000}}, 4'b0000, 4'b1111, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic load_row(input row_t r);
        instr     = {r.f6, r.vm, 5'd2, 5'd1, r.f3, 5'd0, 7'b1010111};
        elem_cnt  = r.cnt;
        ew_sel    = r.ew;
        src_mask  = r.smask;
        scalar_op = r.scal;
        vec_a     = r.a;
        vec_b     = r.b;
        dest_in   = r.din;
    endtask

    task automatic run_row(input int k, input row_t r);
        int edges;
        int lat;
        @(negedge clk);
        load_row(r);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        while (!done && edges < 40) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
        lat = (r.ill || r.cnt == 0) ? 1 : ((r.cnt > 4) ? 5 : r.cnt + 1);
        check(edges == lat, $sformatf("row %0d latency R10", k), edges, lat);
        check(dest_out == r.exp, $sformatf("row %0d mask R3 R5 R6 R7 R9", k), dest_out, r.exp);
        check(illegal == r.ill, $sformatf("row %0d illegal R1 R2 R4", k), illegal, r.ill);
        check(invalid == r.inv, $sformatf("row %0d invalid R8", k), invalid, r.inv);
        check(elem_idx == 0, $sformatf("row %0d index R11", k), elem_idx, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state, R10 R11
        check(!busy && !done, "reset busy/done R10", {busy, done}, 0);
        check(dest_out == 0 && !illegal && !invalid, "reset outputs R4", dest_out, 0);
        check(elem_idx == 0, "reset index R11", elem_idx, 0);

        for (int k = 0; k < ROWS; k++) run_row(k, TABLE[k]);

        // R10 R11: progress during a run
        @(negedge clk);
        load_row(TABLE[0]);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy && elem_idx == 0, "first lane R10 R11", {busy, elem_idx}, 3'b100);
        @(posedge clk);
        @(negedge clk);
        check(busy && elem_idx == 1, "second lane R11", {busy, elem_idx}, 3'b101);
        check(!done, "no early done R10", done, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done && !busy, "done after last lane R10", {done, busy}, 2'b10);
        @(posedge clk);
        @(negedge clk);
        check(!done, "done single cycle R10", done, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R10 actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule